// File: doc/BRIEF.md
# Two-Wire Debug Serial Slave

This block is the slave end of a two-wire debug link. An external master owns the serial clock and shares one data line with the slave. The block runs on the fast system clock. It passes both lines through synchronizers and finds clock edges and the start condition by oversampling. Received bytes are turned into accesses on a simple internal register port, and bytes read from that port are shifted back out. The pad is modelled as three separate signals: data in, data out and output enable.

A transfer opens with a start condition. The byte after it carries a register address and a direction flag. Data bytes follow, and the address steps forward after each one. Every byte takes nine serial clocks. Eight of them move data, most significant bit first. The ninth carries no data and is the slot in which the block performs the register write or fetches the next byte to send. There is no stop condition and no acknowledge bit. A new start at any point ends the current transfer and opens a new one.

Top module: `dbg2w_slave`

## Requirements
- R1: A synchronous active-high reset leaves the block idle. Output enable is low, data out is high, and neither port strobe is asserted while reset is held or in the first cycle after it.
- R2: A start is a falling edge of the data line while the serial clock is high. Data changes made while the clock is low never count as a start.
- R3: In receive phases, one bit is taken on each rising edge of the serial clock, most significant bit first. The ninth rising edge of a byte shifts no data.
- R4: The first byte after a start holds the 7-bit register address in bits 7:1 and the direction in bit 0, where 1 means read and 0 means write.
- R5: On the ninth rising clock edge of each write data byte, `reg_wr_en` pulses for one system cycle with `reg_addr` and `reg_wdata`. The address then increments, wrapping from 127 to 0.
- R6: On the ninth rising clock edge of a read address byte, and of every read data byte after it, `reg_rd_en` pulses for one system cycle with `reg_addr`. `reg_rdata` is taken in that same cycle, and the address then increments with wrap.
- R7: While read data is being sent, each bit is driven after a falling edge of the serial clock, most significant bit first. It is valid at most three system cycles after that edge. Output enable is released on the falling edge that opens the ninth clock.
- R8: Output enable stays low in the idle, address and write phases.
- R9: A start in the middle of a byte discards the partial byte. The block then receives a new address byte.
- R10: Serial clock pulses before the first start after reset cause no strobe and no drive.
- R11: `reg_wr_en` and `reg_rd_en` are never asserted together, and each lasts one system cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least twice the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Data line as seen at the pad |
| sda_o | output | 1 | Data value to drive onto the pad |
| sda_oe | output | 1 | Pad output enable, high while driving read data |
| reg_addr | output | 7 | Register address for the current strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr_en` |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Read data, taken in the same cycle as `reg_rd_en` |

## Verification
The assertions check four things on every cycle:
- the two strobes never overlap,
- each strobe lasts exactly one cycle,
- strobes occur only in the cycle where the synchronized serial clock has just risen,
- output enable and driven data change only after the synchronized clock was low.

The remaining behaviour shows only in the bench's scenarios:
- the bit order,
- the address and direction split,
- address increment and wrap,
- the mid-byte abort,
- clocks ignored before a start,
- the correct read bytes leaving in order at full and reduced serial rates.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

    parameter int DBG_ADDR_W = 7;
    parameter int DBG_DATA_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WRITE,
        PH_READ
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
    } line_ev_t;

endpackage

// File: rtl/dbg2w_sync.sv
module dbg2w_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d[b]};
        end

        always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= chain_d;
        end

        assign q[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/dbg2w_edge.sv
module dbg2w_edge
    import dbg2w_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output line_ev_t ev
);

    logic [1:0] prev_d, prev_q;

    always_comb begin
        prev_d   = {scl_s, sda_s};
        ev.rise  = scl_s & ~prev_q[1];
        ev.fall  = ~scl_s & prev_q[1];
        ev.start = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 2'b11;
        else     prev_q <= prev_d;
    end

endmodule

// File: rtl/dbg2w_engine.sv
module dbg2w_engine
    import dbg2w_pkg::*;
#(
    parameter int ADDR_W = DBG_ADDR_W,
    parameter int DATA_W = DBG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic              sda_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              sdo,
    output logic              oe
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shift;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] tx;
        logic              oe;
        logic              sdo;
    } st_t;

    st_t st_d, st_q;
    logic [ADDR_W-1:0] addr_field;

    always_comb begin
        st_d       = st_q;
        reg_wr     = 1'b0;
        reg_rd     = 1'b0;
        reg_addr   = st_q.addr;
        reg_wdata  = st_q.shift;
        addr_field = st_q.shift[DATA_W-1 -: ADDR_W];

        if (ev.start) begin
            st_d.phase = PH_ADDR;
            st_d.cnt   = '0;
            st_d.oe    = 1'b0;
            st_d.sdo   = 1'b1;
        end else begin
            unique case (st_q.phase)
                PH_ADDR, PH_WRITE: begin
                    if (ev.rise) begin
                        if (st_q.cnt != LAST) begin
                            st_d.shift = {st_q.shift[DATA_W-2:0], sda_s};
                            st_d.cnt   = st_q.cnt + CNT_W'(1);
                        end else begin
                            st_d.cnt = '0;
                            if (st_q.phase == PH_ADDR) begin
                                if (st_q.shift[0]) begin
                                    reg_rd     = 1'b1;
                                    reg_addr   = addr_field;
                                    st_d.tx    = rd_data;
                                    st_d.addr  = addr_field + ADDR_W'(1);
                                    st_d.phase = PH_READ;
                                end else begin
                                    st_d.addr  = addr_field;
                                    st_d.phase = PH_WRITE;
                                end
                            end else begin
                                reg_wr    = 1'b1;
                                st_d.addr = st_q.addr + ADDR_W'(1);
                            end
                        end
                    end
                end
                PH_READ: begin
                    if (ev.fall) begin
                        if (st_q.cnt != LAST) begin
                            st_d.oe  = 1'b1;
                            st_d.sdo = st_q.tx[DATA_W-1];
                            st_d.tx  = {st_q.tx[DATA_W-2:0], 1'b0};
                        end else begin
                            st_d.oe  = 1'b0;
                            st_d.sdo = 1'b1;
                        end
                    end
                    if (ev.rise) begin
                        if (st_q.cnt != LAST) begin
                            st_d.cnt = st_q.cnt + CNT_W'(1);
                        end else begin
                            st_d.cnt  = '0;
                            reg_rd    = 1'b1;
                            st_d.tx   = rd_data;
                            st_d.addr = st_q.addr + ADDR_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.sdo   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo = st_q.sdo;
    assign oe  = st_q.oe;

endmodule

// File: rtl/dbg2w_slave.sv
module dbg2w_slave
    import dbg2w_pkg::*;
#(
    parameter int ADDR_W      = DBG_ADDR_W,
    parameter int DATA_W      = DBG_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic [1:0] lines_raw, lines_sync;
    logic       scl_sync, sda_sync;
    line_ev_t   ev;

    assign lines_raw = {scl_i, sda_i};

    dbg2w_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lines_raw),
        .q   (lines_sync)
    );

    assign scl_sync = lines_sync[1];
    assign sda_sync = lines_sync[0];

    dbg2w_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_sync),
        .sda_s (sda_sync),
        .ev    (ev)
    );

    dbg2w_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sda_s     (sda_sync),
        .rd_data   (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr_en),
        .reg_rd    (reg_rd_en),
        .sdo       (sda_o),
        .oe        (sda_oe)
    );

endmodule

// File: rtl/dbg2w_slave_chk.sv
module dbg2w_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic sda_oe,
    input logic sda_o,
    input logic reg_wr_en,
    input logic reg_rd_en
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_oe && sda_o && !reg_wr_en && !reg_rd_en));

    // R11
    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en && reg_rd_en));

    // R11
    a_r11_wr_single: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    // R11
    a_r11_rd_single: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> !reg_rd_en);

    // R5
    a_r5_wr_on_clock_rise: assert property (@(posedge clk) disable iff (rst || !seen_q)
        reg_wr_en |-> (scl_s && !$past(scl_s)));

    // R6
    a_r6_rd_on_clock_rise: assert property (@(posedge clk) disable iff (rst || !seen_q)
        reg_rd_en |-> (scl_s && !$past(scl_s)));

    // R7
    a_r7_oe_rises_after_low: assert property (@(posedge clk) disable iff (rst || !seen_q)
        $rose(sda_oe) |-> !$past(scl_s));

    // R7
    a_r7_data_moves_after_low: assert property (@(posedge clk) disable iff (rst || !seen_q)
        (sda_oe && !$stable(sda_o)) |-> !$past(scl_s));

endmodule

bind dbg2w_slave dbg2w_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_sync),
    .sda_oe    (sda_oe),
    .sda_o     (sda_o),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en)
);

// File: tb/tb_dbg2w_slave.sv
module tb_dbg2w_slave;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic       m_scl, m_sda;
    wire        line;
    logic       sda_o, sda_oe, reg_wr_en, reg_rd_en;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [128];

    assign line      = m_sda & (sda_oe ? sda_o : 1'b1);
    assign reg_rdata = mem[reg_addr];

    dbg2w_slave dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (line),
        .sda_o     (sda_o),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_rdata (reg_rdata)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    task automatic chk(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit hs[$];
    bit hd[$];
    int ph, cnt, sh, ad, tx;
    bit m_oe, m_sdo, cur_oe, cur_sdo;
    bit exp_wr, exp_rd;
    int exp_addr, exp_wdata;

    always @(posedge clk) begin
        if (rst) begin
            hs = {1'b1, 1'b1, 1'b1};
            hd = {1'b1, 1'b1, 1'b1};
            ph = 0; cnt = 0; sh = 0; ad = 0; tx = 0;
            m_oe = 0; m_sdo = 1; cur_oe = 0; cur_sdo = 1;
            exp_wr = 0; exp_rd = 0;
        end else begin
            bit lm, rise, fall, start;
            lm = m_sda & (cur_oe ? cur_sdo : 1'b1);
            cur_oe = m_oe;
            cur_sdo = m_sdo;
            hs.push_back(m_scl);
            hd.push_back(lm);
            void'(hs.pop_front());
            void'(hd.pop_front());
            rise  = hs[1] && !hs[0];
            fall  = !hs[1] && hs[0];
            start = hs[1] && hs[0] && hd[0] && !hd[1];
            exp_wr = 0;
            exp_rd = 0;
            if (start) begin
                ph = 1; cnt = 0; m_oe = 0; m_sdo = 1;
            end else if (ph == 1 || ph == 2) begin
                if (rise) begin
                    if (cnt < 8) begin
                        sh = ((sh << 1) | int'(hd[1])) & 255;
                        cnt++;
                    end else begin
                        cnt = 0;
                        if (ph == 1) begin
                            if (sh % 2 == 1) begin
                                exp_rd = 1; exp_addr = sh / 2;
                                tx = int'(mem[sh / 2]);
                                ad = (sh / 2 + 1) % 128; ph = 3;
                            end else begin
                                ad = sh / 2; ph = 2;
                            end
                        end else begin
                            exp_wr = 1; exp_addr = ad; exp_wdata = sh;
                            ad = (ad + 1) % 128;
                        end
                    end
                end
            end else if (ph == 3) begin
                if (fall) begin
                    if (cnt < 8) begin
                        m_oe = 1; m_sdo = ((tx >> (7 - cnt)) & 1) == 1;
                    end else begin
                        m_oe = 0; m_sdo = 1;
                    end
                end
                if (rise) begin
                    if (cnt < 8) cnt++;
                    else begin
                        cnt = 0; exp_rd = 1; exp_addr = ad;
                        tx = int'(mem[ad]); ad = (ad + 1) % 128;
                    end
                end
            end
        end
    end

    // ---------------- per-cycle comparison and logging ----------------
    int wlog_a[$];
    int wlog_d[$];
    int n_wr = 0, n_rd = 0, n_oe = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk("R8", "sda_oe", int'(sda_oe), int'(cur_oe));
            if (cur_oe) chk("R7", "sda_o", int'(sda_o), int'(cur_sdo));
            chk("R5", "reg_wr_en", int'(reg_wr_en), int'(exp_wr));
            chk("R6", "reg_rd_en", int'(reg_rd_en), int'(exp_rd));
            chk("R11", "both strobes", int'(reg_wr_en && reg_rd_en), 0);
            if (exp_wr) begin
                chk("R5", "write addr", int'(reg_addr), exp_addr);
                chk("R3", "write data", int'(reg_wdata), exp_wdata);
            end
            if (exp_rd) chk("R6", "read addr", int'(reg_addr), exp_addr);
            if (reg_wr_en) begin
                wlog_a.push_back(int'(reg_addr));
                wlog_d.push_back(int'(reg_wdata));
                n_wr++;
            end
            if (reg_rd_en) n_rd++;
            if (sda_oe) n_oe++;
        end
    end

    // ---------------- master tasks ----------------
    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(int h);
        m_sda = 1'b1; wait_n(h);
        m_scl = 1'b1; wait_n(h);
        m_sda = 1'b0; wait_n(h);
        m_scl = 1'b0;
    endtask

    task automatic send_bit(bit b, int h);
        m_sda = b; wait_n(h);
        m_scl = 1'b1; wait_n(h);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(int v, int h);
        for (int i = 7; i >= 0; i--) send_bit(((v >> i) & 1) == 1, h);
        send_bit(1'b1, h);
    endtask

    task automatic recv_byte(int h, output int v);
        v = 0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_n(h);
            v = (v << 1) | int'(line);
            m_scl = 1'b1; wait_n(h);
            m_scl = 1'b0;
        end
        wait_n(h);
        m_scl = 1'b1; wait_n(h);
        m_scl = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_scl = 1'b1; m_sda = 1'b1;
        wait_n(3);
        chk("R1", "oe in reset", int'(sda_oe), 0);
        chk("R1", "sda_o in reset", int'(sda_o), 1);
        chk("R1", "strobes in reset", int'(reg_wr_en | reg_rd_en), 0);
        rst = 1'b0;
        wait_n(1);
        chk("R1", "oe after reset", int'(sda_oe), 0);
        chk("R1", "strobes after reset", int'(reg_wr_en | reg_rd_en), 0);
    endtask

    task automatic chk_log(string req, int idx, int a, int d);
        chk(req, "log addr", (idx < wlog_a.size()) ? wlog_a[idx] : -1, a);
        chk(req, "log data", (idx < wlog_d.size()) ? wlog_d[idx] : -1, d);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        int v;
        int oe0;
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 11) & 255);
        rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1;
        do_reset();

        // R10: clocks and data with no start are ignored
        m_scl = 1'b0; wait_n(2);
        send_byte(8'h55, 2);
        send_byte(8'hA1, 2);
        wait_n(6);
        chk("R10", "writes before start", n_wr, 0);
        chk("R10", "reads before start", n_rd, 0);
        chk("R10", "drive before start", n_oe, 0);

        // R2 R3 R4 R5: write at the fastest serial rate
        do_start(1);
        send_byte({7'h10, 1'b0}, 1);
        send_byte(8'hA5, 1);
        send_byte(8'h3C, 1);
        wait_n(6);
        chk("R2", "writes after start", wlog_a.size(), 2);
        chk_log("R4", 0, 8'h10, 8'hA5);
        chk_log("R5", 1, 8'h11, 8'h3C);

        // R5: address wrap at slower rate
        do_start(3);
        send_byte({7'h7E, 1'b0}, 3);
        send_byte(8'h01, 3);
        send_byte(8'h80, 3);
        send_byte(8'hFF, 3);
        wait_n(8);
        chk_log("R5", 2, 8'h7E, 8'h01);
        chk_log("R5", 3, 8'h7F, 8'h80);
        chk_log("R5", 4, 8'h00, 8'hFF);

        // R9: start mid-byte aborts the partial byte
        do_start(2);
        send_byte({7'h20, 1'b0}, 2);
        send_bit(1'b1, 2); send_bit(1'b0, 2); send_bit(1'b1, 2); send_bit(1'b1, 2);
        do_start(2);
        send_byte({7'h40, 1'b0}, 2);
        send_byte(8'h99, 2);
        wait_n(6);
        chk("R9", "writes after abort", wlog_a.size(), 6);
        chk_log("R9", 5, 8'h40, 8'h99);
        chk("R8", "no drive during writes", n_oe, 0);

        // R6 R7: read three bytes across the address wrap
        do_reset();
        oe0 = n_rd;
        m_scl = 1'b0; wait_n(2);
        do_start(4);
        send_byte({7'h7E, 1'b1}, 4);
        recv_byte(4, v);
        chk("R7", "read byte 0", v, int'(mem[7'h7E]));
        recv_byte(4, v);
        chk("R7", "read byte 1", v, int'(mem[7'h7F]));
        recv_byte(4, v);
        chk("R6", "read byte 2 after wrap", v, int'(mem[7'h00]));
        chk("R6", "read fetches", n_rd - oe0, 4);
        chk("R5", "no writes during read", wlog_a.size(), 6);

        do_reset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog (R1..R11 run): finished=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule